// File: doc/BRIEF.md
# Keyboard Input Port for a Pulsed I/O Bus

This block is the device side of a keyboard attached to a processor I/O bus. Each keystroke strobes a 7-bit character code into a holding register and sets a ready flag. The processor reaches the port with an I/O instruction. That instruction puts a 6-bit device address on the bus and then emits up to three timed function pulses, one after another. Only while its own address is on the bus does the port answer those pulses. The first pulse tests the flag and requests a skip. The second clears the accumulator and the flag. The third merges the character into the accumulator.

All three return paths are wired-OR: skip request, accumulator clear and data-in. The port drives them high only while it is answering a pulse and holds them low at every other time, so other devices can share them. Several function bits may be set in one instruction. The pulses then arrive in order, and the port answers each against the state left by the one before. For example, clear followed by read gives a clear-and-load of the accumulator.

Top module: `kbd_bus_if`

## Requirements
- R1: After reset the ready flag and the character register are 0, and skip_o, clr_ac_o and data_in_o are all 0.
- R2: The port answers only when bus_addr equals DEV_ADDR (default octal 03, binary 000011). At any other address, pulses produce no output and leave the flag unchanged.
- R3: A cycle with key_strobe high stores key_code in the character register and sets the ready flag.
- R4: While the port is addressed and iop_i[0] is high, skip_o equals the ready flag. skip_o is 0 whenever iop_i[0] is low.
- R5: While the port is addressed and iop_i[1] is high, clr_ac_o is 1. At that clock edge the ready flag is cleared.
- R6: While the port is addressed and iop_i[2] is high, data_in_o[6:0] carries the stored character. data_in_o[11:7] are 0 at all times.
- R7: When pulses iop_i[0], iop_i[1] and iop_i[2] arrive in sequence within one instruction, the skip reflects the flag before the clear, and the read still returns the stored character after the clear.
- R8: If key_strobe and an addressed clear fall in the same cycle, the keystroke wins: the flag ends up set and the new code is stored.
- R9: With no function pulse high, all return outputs are 0 even when the port is addressed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| key_strobe | input | 1 | One-cycle keystroke strobe |
| key_code | input | 7 | Character code of the key |
| bus_addr | input | 6 | Device address field from the bus |
| iop_i | input | 3 | Function pulses: bit0 skip test, bit1 clear, bit2 read |
| skip_o | output | 1 | Wired-OR skip request |
| clr_ac_o | output | 1 | Wired-OR accumulator clear |
| data_in_o | output | 12 | Wired-OR data-in lines to the accumulator |

## Verification
The bench builds the port with its defaults: a 6-bit address at octal 03, a 7-bit character and a 12-bit data path. With these settings, every near-miss address that differs from 03 in a single bit can be driven directly, as can the top data bits that must stay low. The tests cover each function pulse on its own and the combined sequences 011, 110 and 111. They also include a keystroke that lands in the same cycle as a clear, so the ordering rules can be observed at the pins.

// File: rtl/kbd_pkg.sv
package kbd_pkg;
  localparam int FN_W = 3;

  typedef struct packed {
    logic rd;
    logic clr;
    logic tst;
  } kbd_fn_t;

  function automatic kbd_fn_t fn_gate(input logic hit, input logic [FN_W-1:0] iop);
    kbd_fn_t f;
    f.tst = hit & iop[0];
    f.clr = hit & iop[1];
    f.rd  = hit & iop[2];
    return f;
  endfunction
endpackage

// File: rtl/kbd_addr_match.sv
module kbd_addr_match #(
  parameter int ADDR_W = 6,
  parameter logic [ADDR_W-1:0] DEV_ADDR = 6'o03
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o
);
  always_comb hit_o = (addr_i == DEV_ADDR);
endmodule

// File: rtl/kbd_hold.sv
module kbd_hold #(
  parameter int CHAR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_stb_i,
  input  logic [CHAR_W-1:0] key_code_i,
  input  logic              clr_evt_i,
  output logic              ready_o,
  output logic [CHAR_W-1:0] char_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ready_o <= 1'b0;
      char_o  <= '0;
    end else if (key_stb_i) begin
      ready_o <= 1'b1;
      char_o  <= key_code_i;
    end else if (clr_evt_i) begin
      ready_o <= 1'b0;
    end
  end

  assert_key_loads_R3: assert property (@(posedge clk) disable iff (!rst_n)
    key_stb_i |=> (ready_o && char_o == $past(key_code_i)));
  assert_clear_drops_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_evt_i && !key_stb_i) |=> !ready_o);
  assert_key_beats_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_evt_i && key_stb_i) |=> ready_o);
  assert_char_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !key_stb_i |=> $stable(char_o));
endmodule

// File: rtl/kbd_drive.sv
module kbd_drive #(
  parameter int CHAR_W = 7,
  parameter int DATA_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  kbd_pkg::kbd_fn_t   fn_i,
  input  logic               ready_i,
  input  logic [CHAR_W-1:0]  char_i,
  output logic               skip_o,
  output logic               clr_o,
  output logic [DATA_W-1:0]  data_o
);
  localparam int PAD_W = DATA_W - CHAR_W;

  always_comb begin
    skip_o = fn_i.tst & ready_i;
    clr_o  = fn_i.clr;
    data_o = fn_i.rd ? {{PAD_W{1'b0}}, char_i} : '0;
  end

  assert_skip_only_when_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
    skip_o |-> (ready_i && fn_i.tst));
  assert_upper_lines_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    data_o[DATA_W-1:CHAR_W] == '0);
  assert_quiet_without_fn_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fn_i == '0) |-> (!skip_o && !clr_o && data_o == '0));
endmodule

// File: rtl/kbd_bus_if.sv
module kbd_bus_if #(
  parameter int ADDR_W = 6,
  parameter logic [ADDR_W-1:0] DEV_ADDR = 6'o03,
  parameter int CHAR_W = 7,
  parameter int DATA_W = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     key_strobe,
  input  logic [CHAR_W-1:0]        key_code,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [kbd_pkg::FN_W-1:0] iop_i,
  output logic                     skip_o,
  output logic                     clr_ac_o,
  output logic [DATA_W-1:0]        data_in_o
);
  logic              hit;
  kbd_pkg::kbd_fn_t  fn;
  logic              ready;
  logic [CHAR_W-1:0] chr;

  kbd_addr_match #(.ADDR_W(ADDR_W), .DEV_ADDR(DEV_ADDR)) u_match (
    .addr_i(bus_addr), .hit_o(hit));

  always_comb fn = kbd_pkg::fn_gate(hit, iop_i);

  kbd_hold #(.CHAR_W(CHAR_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .key_stb_i(key_strobe), .key_code_i(key_code),
    .clr_evt_i(fn.clr), .ready_o(ready), .char_o(chr));

  kbd_drive #(.CHAR_W(CHAR_W), .DATA_W(DATA_W)) u_drive (
    .clk(clk), .rst_n(rst_n), .fn_i(fn), .ready_i(ready), .char_i(chr),
    .skip_o(skip_o), .clr_o(clr_ac_o), .data_o(data_in_o));

  assert_foreign_addr_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr != DEV_ADDR) |-> (!skip_o && !clr_ac_o && data_in_o == '0));
  assert_foreign_keeps_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr != DEV_ADDR && !key_strobe) |=> (ready == $past(ready)));
  assert_clear_line_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == DEV_ADDR && iop_i[1]) |-> clr_ac_o);
endmodule

// File: tb/kbd_bus_if_test.sv
module kbd_bus_if_test;
  localparam logic [5:0] DEV = 6'o03;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic key_strobe = 1'b0;
  logic [6:0] key_code = '0;
  logic [5:0] bus_addr = '0;
  logic [2:0] iop_i = '0;
  logic skip_o, clr_ac_o;
  logic [11:0] data_in_o;

  int errors = 0;
  int checks = 0;
  logic m_flag = 1'b0;
  logic [6:0] m_char = '0;

  always #10 clk = ~clk;

  kbd_bus_if uut (.clk(clk), .rst_n(rst_n), .key_strobe(key_strobe), .key_code(key_code),
    .bus_addr(bus_addr), .iop_i(iop_i), .skip_o(skip_o), .clr_ac_o(clr_ac_o),
    .data_in_o(data_in_o));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic quiet(input string req);
    check(req, {31'd0, skip_o}, 0);
    check(req, {31'd0, clr_ac_o}, 0);
    check(req, {20'd0, data_in_o}, 0);
  endtask

  task automatic key(input logic [6:0] c);
    @(negedge clk); key_strobe = 1'b1; key_code = c;
    @(posedge clk); #1 m_flag = 1'b1; m_char = c;
    @(negedge clk); key_strobe = 1'b0;
  endtask

  // one function pulse of one cycle, checked against the bench model
  task automatic phase(input logic [5:0] a, input int idx, input string req);
    logic hit;
    hit = (a == DEV);
    @(negedge clk); bus_addr = a; iop_i = 3'b001 << idx;
    #5;
    check({req, " skip"}, {31'd0, skip_o}, {31'd0, hit && idx == 0 && m_flag});
    check({req, " clr"}, {31'd0, clr_ac_o}, {31'd0, hit && idx == 1});
    check({req, " data"}, {20'd0, data_in_o}, (hit && idx == 2) ? {25'd0, m_char} : 32'd0);
    @(posedge clk); #1 if (hit && idx == 1) m_flag = 1'b0;
    @(negedge clk); iop_i = '0;
  endtask

  task automatic instr(input logic [5:0] a, input logic [2:0] fn, input string req);
    for (int i = 0; i < 3; i++) if (fn[i]) phase(a, i, req);
  endtask

  task automatic t_reset;
    #5; quiet("R1 reset outputs");
    instr(DEV, 3'b101, "R1 reset flag/char");
  endtask

  task automatic t_key_and_skip;
    key(7'h41);
    instr(DEV, 3'b001, "R3 R4 skip after key");
    instr(DEV, 3'b100, "R3 R6 read char");
    check("R4 skip low after pulse", {31'd0, skip_o}, 0);
  endtask

  task automatic t_idle;
    @(negedge clk); bus_addr = DEV; iop_i = '0; #5;
    quiet("R9 idle addressed");
  endtask

  task automatic t_wrong_addr;
    for (int b = 0; b < 6; b++) instr(DEV ^ (6'd1 << b), 3'b111, "R2 foreign addr");
    instr(DEV, 3'b001, "R2 flag kept");
  endtask

  task automatic t_clear;
    key(7'h5a);
    instr(DEV, 3'b010, "R5 clear");
    instr(DEV, 3'b001, "R5 flag cleared no skip");
  endtask

  task automatic t_combined;
    key(7'h33);
    instr(DEV, 3'b110, "R7 clear-and-load");
    instr(DEV, 3'b001, "R7 flag after 110");
    key(7'h7f);
    instr(DEV, 3'b111, "R7 full sequence");
    key(7'h01);
    instr(DEV, 3'b011, "R7 skip then clear");
  endtask

  task automatic t_race;
    instr(DEV, 3'b010, "R8 prep clear");
    @(negedge clk); key_strobe = 1'b1; key_code = 7'h2c; bus_addr = DEV; iop_i = 3'b010;
    #5 check("R8 clr line in race", {31'd0, clr_ac_o}, 1);
    @(posedge clk); #1 m_flag = 1'b1; m_char = 7'h2c;
    @(negedge clk); key_strobe = 1'b0; iop_i = '0;
    instr(DEV, 3'b101, "R8 keystroke wins");
  endtask

  initial begin
    #2000000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 t_reset();
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    t_key_and_skip();
    t_idle();
    t_wrong_addr();
    t_clear();
    t_combined();
    t_race();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule